// File: doc/BRIEF.md
# ADC Result Compare Monitor

This block sits beside an analog-to-digital converter's result path and watches the stream of finished conversions. Each conversion arrives as one beat carrying a sample-slot index (0 to 18) and a 12-bit result. Four compare units each pick one slot and test that slot's results against a programmed threshold. A unit's flag rises only after its condition has held for a programmed number of consecutive results from its slot.

Units are grouped in pairs (0/1 and 2/3). A pair can be switched into window mode. In that mode the lower unit's flag reports that both units of the pair are satisfied at once. Typically one unit tests "at or above a low bound" and the other tests "below a high bound", so the pair detects a result inside the window.

Flags stay set until software clears them by writing 1. A single interrupt request line combines the flags of the units whose interrupt is enabled. The result input never back-pressures: its ready output is held high.

Top module: `cmpmon_top`

## Requirements
- R1: A unit's condition bit at 0 means "result less than threshold"; at 1 it means "result greater than or equal to threshold". The threshold is 12 bits wide (0 to 0xFFF).
- R2: A unit's flag sets once its run of consecutive passing results reaches the 4-bit match field plus one (1 to 16). The flag is visible on the outputs after the clock edge that accepts the completing result. Every further passing result while the run is complete keeps the flag set.
- R3: A result from the unit's selected slot that fails the condition resets that unit's run to zero.
- R4: Results tagged with another slot, or with a slot index of 19 or above, leave the run unchanged.
- R5: A unit whose enable bit is 0 (an all-zero configuration) holds its run at zero and never sets its flag.
- R6: A set flag stays set until a clear pulse of 1 on its bit, which clears it at the next edge. If a set and a clear arrive in the same cycle, the set wins.
- R7: With a pair's window bit at 1, the lower flag sets only when both units of the pair have complete runs after a result. The upper flag of that pair does not set.
- R8: The interrupt output is high whenever any set flag has its unit's interrupt-enable bit at 1.
- R9: The result input's ready output is 1 in every cycle after reset. A beat is accepted in any cycle where the valid input is 1.
- R10: After reset all flags are 0, all runs are zero and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result beat valid |
| res_ready | output | 1 | Always 1; the monitor never stalls the result stream |
| res_slot | input | 5 | Sample-slot index of the beat |
| res_data | input | 12 | Conversion result |
| cfg_en | input | 4 | Per-unit enable |
| cfg_cond | input | 4 | Per-unit condition (0 less-than, 1 greater-or-equal) |
| cfg_ie | input | 4 | Per-unit interrupt enable |
| cfg_pair_win | input | 2 | Window mode per pair (bit 0 pair 0/1, bit 1 pair 2/3) |
| cfg_slot | input | 20 | Per-unit slot select, unit n in bits 5n+4:5n |
| cfg_thr | input | 48 | Per-unit threshold, unit n in bits 12n+11:12n |
| cfg_mcnt | input | 16 | Per-unit match count minus one, unit n in bits 4n+3:4n |
| flag_clr | input | 4 | Write-1-to-clear pulse per flag |
| cmp_flag | output | 4 | Sticky compare flags |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Runs and flags are registered on the edge that accepts a beat, so every flag change, and the interrupt that follows it, is due one edge after the beat or clear pulse is driven. Nothing later depends on it. The bench drives each beat just after a falling edge and updates its reference model at the following rising edge from the same inputs. It then compares the flag vector, the interrupt and the ready output at the next falling edge, once per clock. Clears, slot mismatches, broken runs and window combinations are therefore each checked in exactly the cycle they should take effect.

// File: rtl/cmpmon_pkg.sv
package cmpmon_pkg;

  // Condition encoding shared by the units and the bench.
  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_GE = 1'b1
  } cmp_cond_e;

  // Default geometry of the monitor.
  localparam int unsigned DEF_UNITS  = 4;
  localparam int unsigned DEF_SLOTS  = 19;
  localparam int unsigned DEF_SLOT_W = 5;
  localparam int unsigned DEF_DATA_W = 12;
  localparam int unsigned DEF_MCNT_W = 4;

endpackage

// File: rtl/cmpmon_unit.sv
module cmpmon_unit
  import cmpmon_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_SLOTS,
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned MCNT_W    = DEF_MCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_cond,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [DATA_W-1:0] cfg_thr,
  input  logic [MCNT_W-1:0] cfg_mcnt,
  input  logic              in_valid,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [DATA_W-1:0] in_data,
  output logic              hit,
  output logic              sat
);

  localparam int unsigned RUN_W = MCNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(1 << MCNT_W);
  localparam logic [SLOT_W:0]  SLOT_LIM = (SLOT_W+1)'(NUM_SLOTS);

  logic [RUN_W-1:0] run_q, run_d, need;
  logic             slot_ok, sel, pass;

  always_comb begin
    slot_ok = ({1'b0, in_slot} < SLOT_LIM);
    sel     = cfg_en & in_valid & slot_ok & (in_slot == cfg_slot);
    if (cmp_cond_e'(cfg_cond) == CMP_GE) pass = (in_data >= cfg_thr);
    else                                 pass = (in_data <  cfg_thr);
    need = {1'b0, cfg_mcnt} + RUN_W'(1);
    run_d = run_q;
    if (!cfg_en) begin
      run_d = '0;
    end else if (sel) begin
      if (!pass)                run_d = '0;
      else if (run_q < RUN_MAX) run_d = run_q + RUN_W'(1);
    end
    sat = (run_d >= need);
    hit = sel & pass & sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/cmpmon_pair.sv
module cmpmon_pair
  import cmpmon_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_SLOTS,
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned MCNT_W    = DEF_MCNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win,
  input  logic [1:0]          cfg_en,
  input  logic [1:0]          cfg_cond,
  input  logic [2*SLOT_W-1:0] cfg_slot,
  input  logic [2*DATA_W-1:0] cfg_thr,
  input  logic [2*MCNT_W-1:0] cfg_mcnt,
  input  logic                in_valid,
  input  logic [SLOT_W-1:0]   in_slot,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [1:0]          clr,
  output logic [1:0]          flag
);

  logic [1:0] hit, sat, set;
  logic [1:0] flag_q;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    cmpmon_unit #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
      .DATA_W(DATA_W), .MCNT_W(MCNT_W)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_en   (cfg_en[u]),
      .cfg_cond (cfg_cond[u]),
      .cfg_slot (cfg_slot[u*SLOT_W +: SLOT_W]),
      .cfg_thr  (cfg_thr[u*DATA_W +: DATA_W]),
      .cfg_mcnt (cfg_mcnt[u*MCNT_W +: MCNT_W]),
      .in_valid (in_valid),
      .in_slot  (in_slot),
      .in_data  (in_data),
      .hit      (hit[u]),
      .sat      (sat[u])
    );
  end

  // Window: lower flag needs both runs complete after a result touched
  // either unit; the upper flag is parked.
  always_comb begin
    if (win) begin
      set[0] = (hit[0] | hit[1]) & sat[0] & sat[1];
      set[1] = 1'b0;
    end else begin
      set = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | set;
  end

  assign flag = flag_q;

endmodule

// File: rtl/cmpmon_top.sv
module cmpmon_top
  import cmpmon_pkg::*;
#(
  parameter int unsigned NUM_UNITS = DEF_UNITS,
  parameter int unsigned NUM_SLOTS = DEF_SLOTS,
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned MCNT_W    = DEF_MCNT_W,
  localparam int unsigned NUM_PAIRS = NUM_UNITS / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        res_valid,
  output logic                        res_ready,
  input  logic [SLOT_W-1:0]           res_slot,
  input  logic [DATA_W-1:0]           res_data,
  input  logic [NUM_UNITS-1:0]        cfg_en,
  input  logic [NUM_UNITS-1:0]        cfg_cond,
  input  logic [NUM_UNITS-1:0]        cfg_ie,
  input  logic [NUM_PAIRS-1:0]        cfg_pair_win,
  input  logic [NUM_UNITS*SLOT_W-1:0] cfg_slot,
  input  logic [NUM_UNITS*DATA_W-1:0] cfg_thr,
  input  logic [NUM_UNITS*MCNT_W-1:0] cfg_mcnt,
  input  logic [NUM_UNITS-1:0]        flag_clr,
  output logic [NUM_UNITS-1:0]        cmp_flag,
  output logic                        cmp_irq
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    cmpmon_pair #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
      .DATA_W(DATA_W), .MCNT_W(MCNT_W)
    ) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .win      (cfg_pair_win[p]),
      .cfg_en   (cfg_en[2*p +: 2]),
      .cfg_cond (cfg_cond[2*p +: 2]),
      .cfg_slot (cfg_slot[2*p*SLOT_W +: 2*SLOT_W]),
      .cfg_thr  (cfg_thr[2*p*DATA_W +: 2*DATA_W]),
      .cfg_mcnt (cfg_mcnt[2*p*MCNT_W +: 2*MCNT_W]),
      .in_valid (res_valid),
      .in_slot  (res_slot),
      .in_data  (res_data),
      .clr      (flag_clr[2*p +: 2]),
      .flag     (cmp_flag[2*p +: 2])
    );
  end

  assign res_ready = 1'b1;
  assign cmp_irq   = |(cmp_flag & cfg_ie);

endmodule

// File: rtl/cmpmon_chk.sv
module cmpmon_chk #(
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned NUM_PAIRS = NUM_UNITS / 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [NUM_UNITS-1:0] cfg_en,
  input logic [NUM_PAIRS-1:0] cfg_pair_win,
  input logic [NUM_UNITS-1:0] flag_clr,
  input logic [NUM_UNITS-1:0] cmp_flag,
  input logic                 cmp_irq
);

  // R2: with no beat, no flag can rise.
  a_r2_no_set_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> ((cmp_flag & ~$past(cmp_flag)) == '0));

  // R8: interrupt only with some flag set.
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> (cmp_flag != '0));

  // R9: never back-pressure.
  a_r9_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_ready);

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_u
    // R6: sticky until cleared.
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag[i] && !flag_clr[i]) |=> cmp_flag[i]);
    // R6: clear without a competing beat empties the flag.
    a_r6_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !res_valid) |=> !cmp_flag[i]);
    // R5: disabled unit never raises its flag.
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en[i] && !cmp_flag[i]) |=> !cmp_flag[i]);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_p
    // R7: upper flag parked in window mode.
    a_r7_upper_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pair_win[p] && !cmp_flag[2*p+1]) |=> !cmp_flag[2*p+1]);
  end

endmodule

bind cmpmon_top cmpmon_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .cfg_en       (cfg_en),
  .cfg_pair_win (cfg_pair_win),
  .flag_clr     (flag_clr),
  .cmp_flag     (cmp_flag),
  .cmp_irq      (cmp_irq)
);

// File: tb/cmpmon_top_tb.sv
module cmpmon_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NU = 4;
  localparam int SW = 5;
  localparam int DW = 12;
  localparam int MW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             res_valid = 1'b0;
  logic             res_ready;
  logic [SW-1:0]    res_slot = '0;
  logic [DW-1:0]    res_data = '0;
  logic [NU-1:0]    cfg_en = '0, cfg_cond = '0, cfg_ie = '0, flag_clr = '0;
  logic [NU/2-1:0]  cfg_pair_win = '0;
  logic [NU*SW-1:0] cfg_slot = '0;
  logic [NU*DW-1:0] cfg_thr = '0;
  logic [NU*MW-1:0] cfg_mcnt = '0;
  logic [NU-1:0]    cmp_flag;
  logic             cmp_irq;

  int checks = 0;
  int errors = 0;
  int run_m [NU];
  bit flag_m [NU];

  cmpmon_top u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_slot(res_slot), .res_data(res_data), .cfg_en(cfg_en),
    .cfg_cond(cfg_cond), .cfg_ie(cfg_ie), .cfg_pair_win(cfg_pair_win),
    .cfg_slot(cfg_slot), .cfg_thr(cfg_thr), .cfg_mcnt(cfg_mcnt),
    .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: one call per rising edge, from the inputs of that edge.
  task automatic model_edge();
    bit sel [NU];
    bit ok  [NU];
    bit done[NU];
    bit set [NU];
    for (int i = 0; i < NU; i++) begin
      int thr  = int'(cfg_thr[i*DW +: DW]);
      int need = int'(cfg_mcnt[i*MW +: MW]) + 1;
      int d    = int'(res_data);
      sel[i] = cfg_en[i] && res_valid && (int'(res_slot) < 19) &&
               (res_slot == cfg_slot[i*SW +: SW]);
      ok[i]  = cfg_cond[i] ? (d >= thr) : (d < thr);
      if (!cfg_en[i]) run_m[i] = 0;
      else if (sel[i]) run_m[i] = ok[i] ? ((run_m[i] < 16) ? run_m[i] + 1 : 16) : 0;
      done[i] = (run_m[i] >= need);
    end
    for (int p = 0; p < NU/2; p++) begin
      int lo = 2*p;
      int hi = 2*p + 1;
      if (cfg_pair_win[p]) begin
        set[lo] = ((sel[lo] && ok[lo]) || (sel[hi] && ok[hi])) && done[lo] && done[hi];
        set[hi] = 1'b0;
      end else begin
        set[lo] = sel[lo] && ok[lo] && done[lo];
        set[hi] = sel[hi] && ok[hi] && done[hi];
      end
    end
    for (int i = 0; i < NU; i++) flag_m[i] = (flag_m[i] && !flag_clr[i]) || set[i];
  endtask

  task automatic compare(input string tag);
    logic [NU-1:0] ef;
    logic          ei;
    ei = 1'b0;
    for (int i = 0; i < NU; i++) begin
      ef[i] = flag_m[i];
      if (flag_m[i] && cfg_ie[i]) ei = 1'b1;
    end
    checks++;
    if (cmp_flag !== ef || cmp_irq !== ei || res_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s: flag=%b irq=%b ready=%b expected flag=%b irq=%b ready=1",
               tag, cmp_flag, cmp_irq, res_ready, ef, ei);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, check at next fall.
  task automatic step(input bit v, input int slot, input int data,
                      input logic [NU-1:0] clr, input string tag);
    res_valid = v;
    res_slot  = SW'(slot);
    res_data  = DW'(data);
    flag_clr  = clr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    res_valid = 1'b0;
    flag_clr  = '0;
  endtask

  task automatic set_unit(input int i, input bit en, input bit cond, input bit ie,
                          input int slot, input int thr, input int mcnt);
    cfg_en[i]   = en;
    cfg_cond[i] = cond;
    cfg_ie[i]   = ie;
    cfg_slot[i*SW +: SW] = SW'(slot);
    cfg_thr[i*DW +: DW]  = DW'(thr);
    cfg_mcnt[i*MW +: MW] = MW'(mcnt);
  endtask

  initial begin
    for (int i = 0; i < NU; i++) begin run_m[i] = 0; flag_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10 reset state");
    step(1'b1, 3, 12'hFFF, '0, "R9 R10 ready and quiet after reset");

    // Unit 0: slot 3, >= 0x800, three in a row.
    set_unit(0, 1, 1, 0, 3, 12'h800, 2);
    step(1'b1, 3, 12'h900, '0, "R2 run 1 no flag");
    step(1'b1, 3, 12'h800, '0, "R1 equal passes ge, run 2");
    step(1'b1, 5, 12'h000, '0, "R4 other slot keeps run");
    step(1'b1, 3, 12'h7FF, '0, "R3 fail resets run");
    step(1'b1, 3, 12'hA00, '0, "R3 run restarts at 1");
    step(1'b1, 3, 12'hFFF, '0, "R2 run 2 no flag");
    step(1'b0, 3, 12'hFFF, '0, "R2 idle cycle keeps run");
    step(1'b1, 25, 12'hFFF, '0, "R4 slot above 18 ignored");
    step(1'b1, 3, 12'h800, '0, "R2 third pass sets flag");
    step(1'b0, 0, 0, '0, "R6 flag holds");
    step(1'b0, 0, 0, 4'b0001, "R6 clear by write one");
    step(1'b1, 3, 12'h801, 4'b0001, "R6 set wins over clear");
    step(1'b0, 0, 0, 4'b0001, "R6 cleared again");

    // Unit 1: slot 9, < 0x200, single match, interrupt enabled.
    set_unit(1, 1, 0, 1, 9, 12'h200, 0);
    step(1'b1, 9, 12'h200, '0, "R1 equal fails lt");
    step(1'b1, 9, 12'h1FF, '0, "R1 R8 lt match flags and irq");
    step(1'b0, 0, 0, 4'b0010, "R8 irq drops with flag");
    cfg_ie[0] = 1'b0;
    step(1'b1, 3, 12'hFFF, '0, "R8 flag without enable no irq");
    step(1'b0, 0, 0, 4'b0001, "R6 clear unit 0");

    // Unit 3 configured but disabled.
    set_unit(3, 0, 1, 1, 4, 12'h000, 0);
    step(1'b1, 4, 12'h123, '0, "R5 disabled unit silent");
    set_unit(3, 0, 0, 0, 0, 0, 0);
    step(1'b1, 0, 12'h000, '0, "R5 all-zero config silent");

    // Window pair 2/3 on slot 7: 0x400 <= x < 0x600, two in a row.
    set_unit(2, 1, 1, 1, 7, 12'h400, 1);
    set_unit(3, 1, 0, 1, 7, 12'h600, 1);
    cfg_pair_win[1] = 1'b1;
    step(1'b1, 7, 12'h500, '0, "R7 inside once no flag");
    step(1'b1, 7, 12'h700, '0, "R7 above window breaks upper run");
    step(1'b1, 7, 12'h5FF, '0, "R7 inside again run 1");
    step(1'b1, 7, 12'h400, '0, "R7 both complete sets lower flag only");
    step(1'b1, 7, 12'h450, 4'b0100, "R7 stays inside set wins");
    step(1'b1, 7, 12'h300, 4'b0100, "R7 below window clears and no set");
    step(1'b1, 7, 12'h500, '0, "R7 upper flag parked");

    // Same pair split back into independent units.
    cfg_pair_win[1] = 1'b0;
    step(1'b1, 7, 12'h500, '0, "R2 independent units both flag");
    step(1'b0, 0, 0, 4'b1111, "R6 clear all");

    // Run saturation: unit 0 needs 16 passes.
    set_unit(0, 1, 0, 0, 1, 12'h010, 15);
    for (int k = 0; k < 15; k++) step(1'b1, 1, k, '0, "R2 long run building");
    step(1'b1, 1, 12'h00F, '0, "R2 sixteenth pass sets flag");
    step(1'b0, 0, 0, 4'b0001, "R6 clear long run flag");
    step(1'b1, 1, 12'h000, '0, "R2 saturated run re-flags");
    step(1'b1, 1, 12'h010, 4'b0001, "R3 fail with clear empties");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule